// File: doc/BRIEF.md
# Counterflow Stage Binding Matcher

This block holds the per-stage rule logic of a counterflow pipeline, in which instructions travel upward and results travel downward. In each evaluation it takes one upward instruction packet and one downward result packet. The instruction packet holds an opcode, two source bindings and one destination binding. The result packet holds two register bindings. The block compares register names between the two packets and fills missing source operands from the passing results. It executes the instruction when this stage has the needed unit. It then makes the downward results agree with the instruction's destination, either by replacing a stale value or by retiring a value that is about to be overwritten. The updated packets appear on registered outputs together with a flag that says the rules have been applied.

Cancellation travels downward in the result packet. A binding that is marked as a trap or as a mispredicted branch disables the instruction it meets and leaves the result packet untouched. A stage that is configured as the last place able to execute an instruction raises a hold flag while an unexecuted live instruction sits in it. The stage-to-stage handshake uses this flag to keep the instruction from moving up.

Top module: `cf_stage`

## Requirements
- R1: While `rst` is high at a clock edge, `instr_out`, `res_out`, `rules_done` and `hold_up` become all zeros.
- R2: A high `eval` at a clock edge loads the evaluated packets into `instr_out`/`res_out` at that edge. `rules_done` is high in exactly the cycles that follow an edge with `eval` high, and the outputs hold their value when `eval` is low. Packet layout, MSB first: the instruction packet is present(1), live(1), op(3), src1, src0, dst. A binding is valid(1), name(4), data(16). The result packet is slot1, slot0, and each slot is kind(2) followed by a binding. The kind encodings are DATA=0, TRAP=1, WRONG_BRANCH=2.
- R3: A source that is not valid and has a non-zero name takes the data of a valid DATA slot with the same name and becomes valid. When both slots match, slot 0 wins. Name 0 never matches.
- R4: A dst that is not valid retires the matching valid DATA slots by clearing their valid bit, and leaves their name and data unchanged.
- R5: A valid dst (either already valid or just executed) copies its data into every DATA slot with the same non-zero name and sets those slots valid.
- R6: The instruction executes only when both sources are valid after filling, its dst is not yet valid, and bit `op` of `UNIT_MASK` is set. The dst then takes the result and becomes valid. Op codes: 0 a+b, 1 a-b, 2 a&b, 3 a|b, 4 a^b, 5 a, 6 low 16 bits of a*b, 7 a<<b[3:0], where a is src0 and b is src1. The default mask is 0x3F.
- R7: A valid dst with a non-zero name that matches no DATA slot is written as a valid DATA binding into slot 0 if slot 0 is not valid. Otherwise it is written into slot 1.
- R8: When a present instruction meets a valid TRAP or WRONG_BRANCH slot, its live bit is cleared. It does no filling or execution, and the result packet passes through unchanged.
- R9: With `LAST_STAGE` set, `hold_up` is high after an evaluation exactly when the instruction is present and live and its dst is still not valid. Otherwise `hold_up` is low.
- R10: An instruction that is absent or already not live passes through unchanged, and it leaves the result packet unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval | input | 1 | Apply the rules to the input packets and register the outcome |
| instr_in | input | 68 | Upward instruction packet |
| res_in | input | 46 | Downward result packet |
| instr_out | output | 68 | Updated instruction packet |
| res_out | output | 46 | Updated result packet |
| rules_done | output | 1 | Rules were applied in the previous cycle |
| hold_up | output | 1 | Instruction must not leave this stage |

## Verification
The bench looks for the following corner cases:
- **Two slots carrying the same name as one source.** A design that gets priority wrong fills the source from slot 1.
- **An invalid destination meeting a valid result.** A design that gets this wrong lets a stale value flow on to younger instructions.
- **A destination that matches no slot while both slots are occupied.** A wrong design drops the fresh value or overwrites the wrong slot.
- **Cancellation markers sitting beside ordinary data.** A wrong design still executes the instruction or edits the result packet.
- **Register name 0, an unsupported opcode, and a dst that is already valid.** A careless design forwards phantom values, executes without a unit, or executes a second time.

// File: rtl/cf_pkg.sv
package cf_pkg;

    parameter int NAME_W = 4;
    parameter int DATA_W = 16;
    parameter int NSLOT  = 2;
    parameter int NSRC   = 2;
    parameter int OP_W   = 3;
    localparam int NOPS  = 1 << OP_W;
    localparam int SHW   = $clog2(DATA_W);

    parameter logic [NOPS-1:0] DEFAULT_MASK = 8'h3F;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_PASS = 3'd5,
        OP_MUL  = 3'd6,
        OP_SHL  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        RK_DATA = 2'd0,
        RK_TRAP = 2'd1,
        RK_WBR  = 2'd2,
        RK_RSVD = 2'd3
    } rkind_e;

    typedef struct packed {
        logic              vld;
        logic [NAME_W-1:0] name;
        logic [DATA_W-1:0] data;
    } bind_t;

    typedef struct packed {
        rkind_e kind;
        bind_t  b;
    } rbind_t;

    typedef struct packed {
        rbind_t [NSLOT-1:0] slot;
    } rpkt_t;

    typedef struct packed {
        logic              present;
        logic              live;
        op_e               op;
        bind_t [NSRC-1:0]  src;
        bind_t             dst;
    } ipkt_t;

    localparam int IPKT_W = $bits(ipkt_t);
    localparam int RPKT_W = $bits(rpkt_t);

    function automatic logic is_marker(input rbind_t r);
        return r.b.vld && (r.kind != RK_DATA);
    endfunction

    function automatic logic name_hit(input rbind_t r, input logic [NAME_W-1:0] n);
        return (r.kind == RK_DATA) && (n != '0) && (r.b.name == n);
    endfunction

endpackage

// File: rtl/cf_src_fill.sv
module cf_src_fill
    import cf_pkg::*;
(
    input  bind_t src_in,
    input  rpkt_t res,
    output bind_t src_out
);
    logic [NSLOT-1:0] hit;

    for (genvar j = 0; j < NSLOT; j++) begin : g_hit
        assign hit[j] = res.slot[j].b.vld && name_hit(res.slot[j], src_in.name);
    end

    always_comb begin
        src_out = src_in;
        if (!src_in.vld) begin
            for (int j = NSLOT - 1; j >= 0; j--) begin
                if (hit[j]) begin
                    src_out.data = res.slot[j].b.data;
                    src_out.vld  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cf_alu.sv
module cf_alu
    import cf_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    logic [2*DATA_W-1:0] prod;

    assign prod = a * b;

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_PASS: y = a;
            OP_MUL:  y = prod[DATA_W-1:0];
            OP_SHL:  y = a << b[SHW-1:0];
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/cf_res_update.sv
module cf_res_update
    import cf_pkg::*;
(
    input  logic  enable,
    input  bind_t dst,
    input  rpkt_t res_in,
    output rpkt_t res_out
);
    logic [NSLOT-1:0] hit;
    logic             any_hit;
    logic             inject;
    logic             tgt;

    for (genvar j = 0; j < NSLOT; j++) begin : g_hit
        assign hit[j] = name_hit(res_in.slot[j], dst.name);
    end

    assign any_hit = |hit;
    assign inject  = enable && dst.vld && (dst.name != '0) && !any_hit;
    assign tgt     = res_in.slot[0].b.vld;

    always_comb begin
        res_out = res_in;
        if (enable) begin
            for (int j = 0; j < NSLOT; j++) begin
                if (hit[j]) begin
                    if (dst.vld) begin
                        res_out.slot[j].b.data = dst.data;
                        res_out.slot[j].b.vld  = 1'b1;
                    end else begin
                        res_out.slot[j].b.vld  = 1'b0;
                    end
                end
            end
            if (inject) begin
                res_out.slot[tgt].kind = RK_DATA;
                res_out.slot[tgt].b    = dst;
            end
        end
    end
endmodule

// File: rtl/cf_stage.sv
module cf_stage
    import cf_pkg::*;
#(
    parameter logic [NOPS-1:0] UNIT_MASK  = DEFAULT_MASK,
    parameter bit              LAST_STAGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eval,
    input  logic [IPKT_W-1:0] instr_in,
    input  logic [RPKT_W-1:0] res_in,
    output logic [IPKT_W-1:0] instr_out,
    output logic [RPKT_W-1:0] res_out,
    output logic              rules_done,
    output logic              hold_up
);
    ipkt_t             ii, io_n, io_q;
    rpkt_t             rr, ro_n, ro_q;
    bind_t [NSRC-1:0]  filled;
    bind_t             dst_new;
    logic [DATA_W-1:0] alu_y;
    logic              kill, active, can_exec, hold_n;
    logic [NSLOT-1:0]  mark;

    assign ii = ipkt_t'(instr_in);
    assign rr = rpkt_t'(res_in);

    for (genvar j = 0; j < NSLOT; j++) begin : g_mark
        assign mark[j] = is_marker(rr.slot[j]);
    end

    assign kill   = ii.present && (|mark);
    assign active = ii.present && ii.live && !kill;

    for (genvar s = 0; s < NSRC; s++) begin : g_fill
        cf_src_fill u_fill (
            .src_in  (ii.src[s]),
            .res     (rr),
            .src_out (filled[s])
        );
    end

    cf_alu u_alu (
        .op (ii.op),
        .a  (filled[0].data),
        .b  (filled[1].data),
        .y  (alu_y)
    );

    assign can_exec = active && !ii.dst.vld && filled[0].vld && filled[1].vld
                      && UNIT_MASK[ii.op];

    always_comb begin
        dst_new = ii.dst;
        if (can_exec) begin
            dst_new.data = alu_y;
            dst_new.vld  = 1'b1;
        end
    end

    cf_res_update u_upd (
        .enable  (active),
        .dst     (dst_new),
        .res_in  (rr),
        .res_out (ro_n)
    );

    always_comb begin
        io_n = ii;
        if (active) begin
            io_n.src = filled;
            io_n.dst = dst_new;
        end
        if (kill) io_n.live = 1'b0;
    end

    assign hold_n = LAST_STAGE && active && !dst_new.vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            io_q       <= '0;
            ro_q       <= '0;
            rules_done <= 1'b0;
            hold_up    <= 1'b0;
        end else begin
            rules_done <= eval;
            if (eval) begin
                io_q    <= io_n;
                ro_q    <= ro_n;
                hold_up <= hold_n;
            end
        end
    end

    assign instr_out = io_q;
    assign res_out   = ro_q;

    // R2: the done flag follows an evaluation by one cycle
    assert_done_R2: assert property (@(posedge clk) disable iff (rst)
        eval |=> rules_done);
    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !eval |=> (!rules_done && $stable(instr_out) && $stable(res_out)));

    // R8: a cancellation marker freezes the result packet and kills the instruction
    assert_kill_R8: assert property (@(posedge clk) disable iff (rst)
        (eval && kill) |=> (res_out == $past(res_in)) && !io_q.live);

    // R6: no execution without a unit for the opcode
    assert_nounit_R6: assert property (@(posedge clk) disable iff (rst)
        (eval && active && !ii.dst.vld && !UNIT_MASK[ii.op]) |=> !io_q.dst.vld);

    // R9: hold only for a live, unexecuted instruction
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        hold_up |-> (io_q.present && io_q.live && !io_q.dst.vld));

    // R3: a freshly filled source carries a value from a matching result slot
    assert_fill_R3: assert property (@(posedge clk) disable iff (rst)
        (active && !ii.src[0].vld && filled[0].vld) |->
        ((rr.slot[0].b.vld && rr.slot[0].b.name == ii.src[0].name
            && rr.slot[0].b.data == filled[0].data) ||
         (rr.slot[1].b.vld && rr.slot[1].b.name == ii.src[0].name
            && rr.slot[1].b.data == filled[0].data)));

    // R7: a valid named destination is present downward after evaluation
    assert_inject_R7: assert property (@(posedge clk) disable iff (rst)
        (eval && active && dst_new.vld && dst_new.name != '0) |=>
        ((ro_q.slot[0].b.vld && ro_q.slot[0].b.name == $past(dst_new.name)
            && ro_q.slot[0].b.data == $past(dst_new.data)) ||
         (ro_q.slot[1].b.vld && ro_q.slot[1].b.name == $past(dst_new.name)
            && ro_q.slot[1].b.data == $past(dst_new.data))));
endmodule

// File: tb/tb_cf_stage.sv
`timescale 1ns/1ps
module tb_cf_stage;
    import cf_pkg::*;

    logic              clk = 1'b0;
    logic              rst, eval;
    logic [IPKT_W-1:0] instr_in, instr_out;
    logic [RPKT_W-1:0] res_in, res_out;
    logic              rules_done, hold_up;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    cf_stage #(.UNIT_MASK(8'h3F), .LAST_STAGE(1'b1)) dut (
        .clk(clk), .rst(rst), .eval(eval),
        .instr_in(instr_in), .res_in(res_in),
        .instr_out(instr_out), .res_out(res_out),
        .rules_done(rules_done), .hold_up(hold_up)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] ref_alu(input op_e op, input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
        logic [31:0] p;
        p = 32'(a) * 32'(b);
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            OP_XOR:  return a ^ b;
            OP_PASS: return a;
            OP_MUL:  return p[15:0];
            default: return a << b[3:0];
        endcase
    endfunction

    function automatic void ref_model(input ipkt_t i, input rpkt_t r,
                                      output ipkt_t io, output rpkt_t ro, output logic hold);
        logic hit;
        int   k;
        io = i; ro = r; hold = 1'b0;
        if (!i.present) return;
        for (int j = 0; j < 2; j++)
            if (r.slot[j].b.vld && r.slot[j].kind != RK_DATA) begin
                io.live = 1'b0;
                return;
            end
        if (!i.live) return;
        for (int s = 0; s < 2; s++)
            if (!io.src[s].vld && io.src[s].name != 0)
                for (int j = 0; j < 2; j++)
                    if (!io.src[s].vld && r.slot[j].b.vld && r.slot[j].kind == RK_DATA
                        && r.slot[j].b.name == io.src[s].name) begin
                        io.src[s].data = r.slot[j].b.data;
                        io.src[s].vld  = 1'b1;
                    end
        if (!io.dst.vld && io.src[0].vld && io.src[1].vld && int'(io.op) < 6) begin
            io.dst.data = ref_alu(io.op, io.src[0].data, io.src[1].data);
            io.dst.vld  = 1'b1;
        end
        hit = 1'b0;
        for (int j = 0; j < 2; j++)
            if (r.slot[j].kind == RK_DATA && io.dst.name != 0 && r.slot[j].b.name == io.dst.name) begin
                if (io.dst.vld) begin
                    ro.slot[j].b.data = io.dst.data;
                    ro.slot[j].b.vld  = 1'b1;
                    hit = 1'b1;
                end else ro.slot[j].b.vld = 1'b0;
            end
        if (io.dst.vld && io.dst.name != 0 && !hit) begin
            k = r.slot[0].b.vld ? 1 : 0;
            ro.slot[k].kind = RK_DATA;
            ro.slot[k].b    = io.dst;
        end
        hold = !io.dst.vld;
    endfunction

    function automatic bind_t mkb(input logic v, input int n, input int d);
        bind_t b;
        b.vld = v; b.name = NAME_W'(n); b.data = DATA_W'(d);
        return b;
    endfunction

    function automatic rbind_t mkr(input rkind_e k, input logic v, input int n, input int d);
        rbind_t r;
        r.kind = k; r.b = mkb(v, n, d);
        return r;
    endfunction

    task automatic run(input string tag, input ipkt_t i, input rpkt_t r,
                       output ipkt_t got_i, output rpkt_t got_r);
        ipkt_t ei; rpkt_t er; logic eh;
        ref_model(i, r, ei, er, eh);
        @(negedge clk);
        instr_in = i; res_in = r; eval = 1'b1;
        @(negedge clk);
        eval = 1'b0;
        got_i = ipkt_t'(instr_out); got_r = rpkt_t'(res_out);
        check({tag, " instr"}, 128'(instr_out), 128'(ei));
        check({tag, " result"}, 128'(res_out), 128'(er));
        check({tag, " hold R9"}, 128'(hold_up), 128'(eh));
        check({tag, " done R2"}, 128'(rules_done), 128'(1'b1));
    endtask

    function automatic ipkt_t mki(input op_e op, input bind_t s0, input bind_t s1, input bind_t d);
        ipkt_t i;
        i.present = 1'b1; i.live = 1'b1; i.op = op;
        i.src[0] = s0; i.src[1] = s1; i.dst = d;
        return i;
    endfunction

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        ipkt_t i, gi; rpkt_t r, gr;
        void'($urandom(32'h5eed_c0de));
        rst = 1'b1; eval = 1'b1; instr_in = '1; res_in = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 instr", 128'(instr_out), 128'(0));
        check("R1 result", 128'(res_out), 128'(0));
        check("R1 flags", 128'({rules_done, hold_up}), 128'(0));
        rst = 1'b0; eval = 1'b0;

        // R3 + R6: ADD fills both sources, slot 0 wins for the shared name
        i = mki(OP_ADD, mkb(0, 2, 0), mkb(0, 3, 0), mkb(0, 5, 0));
        r.slot[0] = mkr(RK_DATA, 1, 2, 5); r.slot[1] = mkr(RK_DATA, 1, 3, 7);
        run("R6 add", i, r, gi, gr);
        check("R6 add value", 128'(gi.dst.data), 128'(12));
        check("R7 inject slot1", 128'(gr.slot[1].b), 128'(mkb(1, 5, 12)));
        i = mki(OP_PASS, mkb(0, 4, 0), mkb(1, 0, 0), mkb(0, 0, 0));
        r.slot[0] = mkr(RK_DATA, 1, 4, 100); r.slot[1] = mkr(RK_DATA, 1, 4, 200);
        run("R3 prio", i, r, gi, gr);
        check("R3 slot0 priority", 128'(gi.src[0].data), 128'(100));

        // R3: name 0 never matches
        i = mki(OP_ADD, mkb(0, 0, 0), mkb(1, 1, 1), mkb(0, 6, 0));
        r.slot[0] = mkr(RK_DATA, 1, 0, 9); r.slot[1] = mkr(RK_DATA, 0, 0, 9);
        run("R3 zero", i, r, gi, gr);
        check("R3 name0 no fill", 128'(gi.src[0].vld), 128'(0));

        // R4: unexecuted dst retires a valid result of the same name
        i = mki(OP_MUL, mkb(1, 1, 3), mkb(1, 2, 4), mkb(0, 7, 0));
        r.slot[0] = mkr(RK_DATA, 1, 7, 55); r.slot[1] = mkr(RK_DATA, 1, 8, 66);
        run("R4 retire", i, r, gi, gr);
        check("R4 slot0 invalid", 128'(gr.slot[0].b), 128'(mkb(0, 7, 55)));
        check("R6 no unit", 128'(gi.dst.vld), 128'(0));
        check("R9 hold", 128'(hold_up), 128'(1));

        // R5: already valid dst overwrites matching slot
        i = mki(OP_ADD, mkb(1, 1, 1), mkb(1, 2, 2), mkb(1, 9, 77));
        r.slot[0] = mkr(RK_DATA, 0, 9, 1); r.slot[1] = mkr(RK_DATA, 1, 3, 4);
        run("R5 update", i, r, gi, gr);
        check("R5 slot0 value", 128'(gr.slot[0].b), 128'(mkb(1, 9, 77)));

        // R7: empty slot 0 receives the injected dst
        i = mki(OP_XOR, mkb(1, 1, 16'hF0F0), mkb(1, 2, 16'h0FF0), mkb(0, 10, 0));
        r.slot[0] = mkr(RK_DATA, 0, 3, 0); r.slot[1] = mkr(RK_DATA, 1, 4, 4);
        run("R7 slot0", i, r, gi, gr);
        check("R7 slot0 value", 128'(gr.slot[0].b), 128'(mkb(1, 10, 16'hFF00)));

        // R8: trap marker cancels, results untouched
        i = mki(OP_ADD, mkb(1, 1, 1), mkb(1, 2, 2), mkb(0, 3, 0));
        r.slot[0] = mkr(RK_DATA, 1, 3, 8); r.slot[1] = mkr(RK_TRAP, 1, 0, 0);
        run("R8 trap", i, r, gi, gr);
        check("R8 result same", 128'(gr), 128'(r));
        check("R8 not live", 128'({gi.live, gi.dst.vld}), 128'(0));
        r.slot[0] = mkr(RK_WBR, 1, 0, 0); r.slot[1] = mkr(RK_DATA, 0, 0, 0);
        run("R8 wbr", i, r, gi, gr);

        // R10: cancelled instruction passes without effect
        i.live = 1'b0;
        r.slot[0] = mkr(RK_DATA, 1, 3, 8); r.slot[1] = mkr(RK_DATA, 1, 1, 9);
        run("R10 dead", i, r, gi, gr);
        check("R10 result same", 128'(gr), 128'(r));

        // R2: outputs hold while eval stays low
        @(negedge clk);
        instr_in = '0; res_in = '0;
        @(negedge clk);
        check("R2 stable", 128'(res_out), 128'(r));
        check("R2 done low", 128'(rules_done), 128'(0));

        // random mix: small name space to force matches
        for (int n = 0; n < 400; n++) begin
            ipkt_t ri; rpkt_t rr;
            ri.present = ($urandom % 8) != 0;
            ri.live    = ($urandom % 8) != 0;
            ri.op      = op_e'($urandom % 8);
            for (int s = 0; s < 2; s++)
                ri.src[s] = mkb($urandom % 2, $urandom % 4, $urandom);
            ri.dst = mkb(($urandom % 4) == 0, $urandom % 4, $urandom);
            for (int j = 0; j < 2; j++)
                rr.slot[j] = mkr((($urandom % 10) == 0) ? rkind_e'(1 + $urandom % 2) : RK_DATA,
                                 $urandom % 2, $urandom % 4, $urandom);
            run("R6 random", ri, rr, gi, gr);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule